// File: doc/BRIEF.md
# Multi-Mode Operand Address Generator

This block takes one already-decoded register-memory instruction and produces its source operand. It forms the effective address for the selected addressing mode, issues one or two reads to a single-port word memory, and adds the operand into the destination register value. For the auto-update modes it also produces the new value of the base register. Each instruction is sequenced by a small state machine. Register values arrive as inputs with their indices, which keeps the register file outside the block. Results leave as two registered write-back channels, one for the destination and one for the base pointer.

A caller asserts `start` for one cycle while the block is idle. All instruction fields are captured on that edge. The block then pulses `done` once, and in that same cycle any write-back enables and data are valid. The memory answers a request one cycle after `mem_req` is sampled.

Top module: `opaddr_gen`

## Requirements
- R1: Mode code 0 (register) yields operand = rs_val, and mode code 1 (immediate) yields operand = imm. Neither issues a memory request. For both, dst_data = rd_val + operand is written to index rd.
- R2: Mode 2 (displacement) reads memory at imm + rs_val. Mode 4 (indexed) reads memory at rs_val + rx_val. The word read is the operand, and dst_data = rd_val + operand.
- R3: Mode 3 (register indirect) reads memory at rs_val. Mode 5 (absolute) reads memory at imm. The word read is added into rd_val.
- R4: Mode 6 (memory indirect) makes two dependent reads. The first is at rs_val and returns a pointer. The second is at that pointer and returns the operand. No two requests occur in consecutive cycles.
- R5: Mode 7 (post-increment) reads at the old rs_val and writes rs_val + d back to index rs.
- R6: Mode 8 (pre-decrement) computes rs_val - d, reads at that address, and writes the same value back to index rs.
- R7: Mode 9 (scaled) reads at imm + rs_val + rx_val * d (modulo 2^32).
- R8: Mode codes 10 to 15 set `illegal` with `done`. They issue no memory request and assert neither write enable, and the operand reads 0.
- R9: When an auto-update mode has rs equal to rd, only the destination write occurs, and the pointer write is suppressed.
- R10: `done` is a one-cycle pulse and write enables are asserted only with it. It rises 1 cycle after the start edge for modes 0, 1 and illegal codes, 3 cycles after it for single-read modes, and 5 cycles after it for mode 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an instruction (sampled when idle) |
| mode | input | 4 | Addressing mode code |
| rd_idx | input | 3 | Destination register index |
| rs_idx | input | 3 | Base register index |
| rd_val | input | 32 | Destination register current value |
| rs_val | input | 32 | Base register current value |
| rx_val | input | 32 | Index register current value |
| imm | input | 32 | Displacement, constant or absolute address |
| d | input | 32 | Scale / step size |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory word address |
| mem_rdata | input | 32 | Read data, valid one cycle after request |
| done | output | 1 | Instruction complete pulse |
| illegal | output | 1 | Unused mode code seen |
| operand | output | 32 | Fetched source operand |
| dst_we | output | 1 | Destination write enable |
| dst_idx | output | 3 | Destination write index |
| dst_data | output | 32 | Destination write data |
| ptr_we | output | 1 | Base pointer write enable |
| ptr_idx | output | 3 | Base pointer write index |
| ptr_data | output | 32 | Base pointer write data |

## Verification
The bench sweeps all sixteen mode codes with several register patterns and checks latency, request count, operand and both write-back channels against arithmetic models. It covers the two pointer-update orders. A design that adds d after the access for pre-decrement, or before it for post-increment, reads the wrong word. It aims at the case where rs equals rd, where a design that lets the pointer write through corrupts the destination. Memory-indirect mode is checked for a second read whose address is the first read's data. If the design reuses the register address, the operand is wrong and the request count drops to one. Codes 10 to 15 must leave both write enables low and the memory idle.

// File: rtl/opag_pkg.sv
package opag_pkg;
    localparam logic [3:0] MD_REG  = 4'd0;
    localparam logic [3:0] MD_IMM  = 4'd1;
    localparam logic [3:0] MD_DISP = 4'd2;
    localparam logic [3:0] MD_RIND = 4'd3;
    localparam logic [3:0] MD_IDX  = 4'd4;
    localparam logic [3:0] MD_ABS  = 4'd5;
    localparam logic [3:0] MD_MIND = 4'd6;
    localparam logic [3:0] MD_AINC = 4'd7;
    localparam logic [3:0] MD_ADEC = 4'd8;
    localparam logic [3:0] MD_SCL  = 4'd9;

    typedef enum logic [2:0] {
        S_IDLE, S_REQ1, S_GOT1, S_REQ2, S_GOT2, S_FIN
    } seq_e;
endpackage

// File: rtl/opag_ea.sv
module opag_ea #(
    parameter int DW = 32
) (
    input  logic [3:0]    mode,
    input  logic [DW-1:0] rs_val,
    input  logic [DW-1:0] rx_val,
    input  logic [DW-1:0] imm,
    input  logic [DW-1:0] d,
    output logic [DW-1:0] addr,
    output logic [DW-1:0] direct_opnd,
    output logic [DW-1:0] ptr_val,
    output logic          ptr_upd,
    output logic          use_mem,
    output logic          two_reads,
    output logic          bad_mode
);
    import opag_pkg::*;

    always_comb begin
        addr        = '0;
        direct_opnd = '0;
        ptr_val     = '0;
        ptr_upd     = 1'b0;
        use_mem     = 1'b1;
        two_reads   = 1'b0;
        bad_mode    = 1'b0;
        case (mode)
            MD_REG:  begin use_mem = 1'b0; direct_opnd = rs_val; end
            MD_IMM:  begin use_mem = 1'b0; direct_opnd = imm;    end
            MD_DISP: addr = imm + rs_val;
            MD_RIND: addr = rs_val;
            MD_IDX:  addr = rs_val + rx_val;
            MD_ABS:  addr = imm;
            MD_MIND: begin addr = rs_val; two_reads = 1'b1; end
            MD_AINC: begin
                addr    = rs_val;
                ptr_val = rs_val + d;
                ptr_upd = 1'b1;
            end
            MD_ADEC: begin
                ptr_val = rs_val - d;
                addr    = rs_val - d;
                ptr_upd = 1'b1;
            end
            MD_SCL:  addr = imm + rs_val + rx_val * d;
            default: begin use_mem = 1'b0; bad_mode = 1'b1; end
        endcase
    end
endmodule

// File: rtl/opag_wb.sv
module opag_wb #(
    parameter int DW = 32,
    parameter int RW = 3
) (
    input  logic          fire,
    input  logic          bad_mode,
    input  logic [RW-1:0] rd_idx,
    input  logic [RW-1:0] rs_idx,
    input  logic [DW-1:0] rd_val,
    input  logic [DW-1:0] opnd,
    input  logic          ptr_upd,
    input  logic          same_reg_ok,
    output logic          dst_we,
    output logic [DW-1:0] dst_data,
    output logic          ptr_we
);
    logic clash;

    always_comb begin
        clash    = (rd_idx == rs_idx);
        dst_we   = fire && !bad_mode;
        dst_data = rd_val + opnd;
        // destination result wins over the pointer update on a shared index
        ptr_we   = fire && !bad_mode && ptr_upd && (!clash || same_reg_ok);
    end
endmodule

// File: rtl/opaddr_gen.sv
module opaddr_gen #(
    parameter int DW = 32,
    parameter int RW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [3:0]    mode,
    input  logic [RW-1:0] rd_idx,
    input  logic [RW-1:0] rs_idx,
    input  logic [DW-1:0] rd_val,
    input  logic [DW-1:0] rs_val,
    input  logic [DW-1:0] rx_val,
    input  logic [DW-1:0] imm,
    input  logic [DW-1:0] d,
    output logic          mem_req,
    output logic [DW-1:0] mem_addr,
    input  logic [DW-1:0] mem_rdata,
    output logic          done,
    output logic          illegal,
    output logic [DW-1:0] operand,
    output logic          dst_we,
    output logic [RW-1:0] dst_idx,
    output logic [DW-1:0] dst_data,
    output logic          ptr_we,
    output logic [RW-1:0] ptr_idx,
    output logic [DW-1:0] ptr_data
);
    import opag_pkg::*;

    typedef struct packed {
        seq_e          st;
        logic [RW-1:0] rd;
        logic [RW-1:0] rs;
        logic [DW-1:0] rdv;
        logic [DW-1:0] addr;
        logic          upd;
        logic [DW-1:0] pval;
        logic          two;
        logic          bad;
        logic [DW-1:0] opnd;
        logic          done;
        logic          dwe;
        logic [DW-1:0] ddata;
        logic          pwe;
    } state_t;

    state_t q, n;

    logic [DW-1:0] ea_addr, ea_direct, ea_pval;
    logic          ea_upd, ea_mem, ea_two, ea_bad;

    opag_ea #(.DW(DW)) u_ea (
        .mode(mode), .rs_val(rs_val), .rx_val(rx_val), .imm(imm), .d(d),
        .addr(ea_addr), .direct_opnd(ea_direct), .ptr_val(ea_pval),
        .ptr_upd(ea_upd), .use_mem(ea_mem), .two_reads(ea_two),
        .bad_mode(ea_bad)
    );

    logic          idle;
    logic          fire;
    logic [DW-1:0] wb_opnd;
    logic          wb_dwe, wb_pwe;
    logic [DW-1:0] wb_ddata;

    assign idle = (q.st == S_IDLE);

    opag_wb #(.DW(DW), .RW(RW)) u_wb (
        .fire(fire),
        .bad_mode(idle ? ea_bad : q.bad),
        .rd_idx(idle ? rd_idx : q.rd),
        .rs_idx(idle ? rs_idx : q.rs),
        .rd_val(idle ? rd_val : q.rdv),
        .opnd(wb_opnd),
        .ptr_upd(idle ? ea_upd : q.upd),
        .same_reg_ok(1'b0),
        .dst_we(wb_dwe), .dst_data(wb_ddata), .ptr_we(wb_pwe)
    );

    always_comb begin
        n       = q;
        n.done  = 1'b0;
        n.dwe   = 1'b0;
        n.pwe   = 1'b0;
        fire    = 1'b0;
        wb_opnd = mem_rdata;
        case (q.st)
            S_IDLE: begin
                wb_opnd = ea_bad ? '0 : ea_direct;
                if (start) begin
                    n.rd   = rd_idx;
                    n.rs   = rs_idx;
                    n.rdv  = rd_val;
                    n.addr = ea_addr;
                    n.upd  = ea_upd;
                    n.pval = ea_pval;
                    n.two  = ea_two;
                    n.bad  = ea_bad;
                    if (ea_mem) begin
                        n.st = S_REQ1;
                    end else begin
                        fire   = 1'b1;
                        n.opnd = ea_bad ? '0 : ea_direct;
                        n.st   = S_FIN;
                    end
                end
            end
            S_REQ1: n.st = S_GOT1;
            S_GOT1: begin
                if (q.two) begin
                    n.addr = mem_rdata;
                    n.st   = S_REQ2;
                end else begin
                    fire   = 1'b1;
                    n.opnd = mem_rdata;
                    n.st   = S_FIN;
                end
            end
            S_REQ2: n.st = S_GOT2;
            S_GOT2: begin
                fire   = 1'b1;
                n.opnd = mem_rdata;
                n.st   = S_FIN;
            end
            default: n.st = S_IDLE;
        endcase
        if (fire) begin
            n.done  = 1'b1;
            n.dwe   = wb_dwe;
            n.ddata = wb_ddata;
            n.pwe   = wb_pwe;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= n;
        end
    end

    assign mem_req  = (q.st == S_REQ1) || (q.st == S_REQ2);
    assign mem_addr = q.addr;
    assign done     = q.done;
    assign illegal  = q.bad;
    assign operand  = q.opnd;
    assign dst_we   = q.dwe;
    assign dst_idx  = q.rd;
    assign dst_data = q.ddata;
    assign ptr_we   = q.pwe;
    assign ptr_idx  = q.rs;
    assign ptr_data = q.pval;

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10
    wb_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_we || ptr_we) |-> done);
    // R8
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && illegal) |-> (!dst_we && !ptr_we));
    // R9
    dst_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_we && ptr_we) |-> (ptr_idx != dst_idx));
    // R4
    req_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);
    // R4
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> $stable(mem_addr));
endmodule

// File: tb/sim_opaddr_gen.sv
module sim_opaddr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  mode = '0;
    logic [2:0]  rd_idx = '0, rs_idx = '0;
    logic [31:0] rd_val = '0, rs_val = '0, rx_val = '0, imm = '0, d = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic [31:0] mem_rdata = '0;
    logic        done, illegal, dst_we, ptr_we;
    logic [31:0] operand, dst_data, ptr_data;
    logic [2:0]  dst_idx, ptr_idx;

    int checks = 0;
    int fails  = 0;
    int nreq   = 0;

    always #2.5 clk = ~clk;

    opaddr_gen u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .rd_idx(rd_idx), .rs_idx(rs_idx), .rd_val(rd_val), .rs_val(rs_val),
        .rx_val(rx_val), .imm(imm), .d(d), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .done(done),
        .illegal(illegal), .operand(operand), .dst_we(dst_we),
        .dst_idx(dst_idx), .dst_data(dst_data), .ptr_we(ptr_we),
        .ptr_idx(ptr_idx), .ptr_data(ptr_data)
    );

    function automatic logic [31:0] memf(input logic [31:0] a);
        return (a * 32'h0001_0003) ^ 32'h5A5A_0000;
    endfunction

    always @(posedge clk) begin
        if (mem_req) begin
            mem_rdata <= memf(mem_addr);
            nreq <= nreq + 1;
        end
    end

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run(input logic [3:0] m, input logic [2:0] rd, input logic [2:0] rs,
                       input logic [31:0] rdv, input logic [31:0] rsv,
                       input logic [31:0] rxv, input logic [31:0] im,
                       input logic [31:0] dd);
        logic [31:0] ea, opn, pv;
        int lat, rq, cyc;
        bit upd, bad;
        upd = 0; bad = 0; ea = '0; opn = '0; pv = '0; lat = 3; rq = 1;
        case (m)
            4'd0: begin opn = rsv; lat = 1; rq = 0; end
            4'd1: begin opn = im;  lat = 1; rq = 0; end
            4'd2: ea = im + rsv;
            4'd3: ea = rsv;
            4'd4: ea = rsv + rxv;
            4'd5: ea = im;
            4'd6: begin opn = memf(memf(rsv)); lat = 5; rq = 2; end
            4'd7: begin ea = rsv; pv = rsv + dd; upd = 1; end
            4'd8: begin pv = rsv - dd; ea = pv; upd = 1; end
            4'd9: ea = im + rsv + rxv * dd;
            default: begin bad = 1; lat = 1; rq = 0; end
        endcase
        if (rq == 1) opn = memf(ea);
        @(negedge clk);
        mode = m; rd_idx = rd; rs_idx = rs; rd_val = rdv; rs_val = rsv;
        rx_val = rxv; imm = im; d = dd; start = 1'b1;
        nreq = 0;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < 20) begin
            @(negedge clk);
            cyc++;
        end
        // R10 latency per mode class
        chk(cyc == lat, "R10 latency", cyc, lat);
        // R1 R4 R8 request count
        chk(nreq == rq, (rq == 2) ? "R4 request count" : (bad ? "R8 request count" : "R1 request count"), nreq, rq);
        if (bad) begin
            chk(illegal && !dst_we && !ptr_we, "R8 illegal quiet",
                {illegal, dst_we, ptr_we}, 3'b100);
            chk(operand == 32'd0, "R8 operand", operand, 0);
        end else begin
            chk(!illegal, "R8 legal mode flag", illegal, 0);
            chk(operand == opn, (m == 4'd9) ? "R7 operand" : (m == 4'd6) ? "R4 operand" :
                (m == 4'd2 || m == 4'd4) ? "R2 operand" : (m == 4'd3 || m == 4'd5) ? "R3 operand" :
                (m == 4'd7) ? "R5 operand" : (m == 4'd8) ? "R6 operand" : "R1 operand", operand, opn);
            chk(dst_we && dst_idx == rd && dst_data == rdv + opn, "R1 R2 R3 destination write",
                dst_data, rdv + opn);
            if (upd && rd != rs) begin
                chk(ptr_we && ptr_idx == rs && ptr_data == pv,
                    (m == 4'd7) ? "R5 pointer update" : "R6 pointer update", ptr_data, pv);
            end else begin
                chk(!ptr_we, upd ? "R9 pointer suppressed" : "R5 R6 no pointer write", ptr_we, 0);
            end
        end
        @(negedge clk);
        chk(!done && !dst_we && !ptr_we, "R10 single pulse", {done, dst_we, ptr_we}, 0);
    endtask

    initial begin
        #900000;
        fails++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!done && !mem_req && !dst_we && !ptr_we, "R10 reset state",
            {done, mem_req, dst_we, ptr_we}, 0);
        rst_n = 1'b1;
        for (int m = 0; m < 16; m++) begin
            for (int k = 0; k < 6; k++) begin
                logic [2:0] rd, rs;
                logic [31:0] b;
                b  = 32'h0000_1000 * (k + 1) + 32'(m * 7);
                rd = 3'(k);
                rs = (k == 0 || k == 3) ? 3'(k) : 3'(k + 2);
                run(4'(m), rd, rs, 32'h100 * k + 32'd5, b, 32'(k * 3 + 1),
                    (k == 5) ? 32'hFFFF_FFF0 : 32'(40 + m), 32'(k + 1));
            end
        end
        // R9 explicit shared index for both update orders
        run(4'd7, 3'd2, 3'd2, 32'd10, 32'h200, 32'd0, 32'd0, 32'd4);
        run(4'd8, 3'd6, 3'd6, 32'd11, 32'h300, 32'd0, 32'd0, 32'd4);
        // R6 R7 wrap-around corners
        run(4'd8, 3'd1, 3'd3, 32'd0, 32'd2, 32'd0, 32'd0, 32'd5);
        run(4'd9, 3'd1, 3'd3, 32'd0, 32'hFFFF_FFFF, 32'h8000_0001, 32'd3, 32'd4);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule